// File: doc/BRIEF.md
# Word-Packing Serial Receiver with Idle Timeout

This block turns an asynchronous serial line carrying frames of one start bit, eight data bits and one stop bit into 32-bit words. Received characters are packed four to a word, and each word is stored in a small first-in first-out buffer that a host drains one word at a time. The line is brought into the clock domain through a two-flop synchronizer and sampled in the middle of each bit, counted with a sixteen-times oversampling tick.

Reception is organised in transfers. Loading a transfer length opens a transfer. The transfer closes when that many characters have arrived, or, if idle detection is armed, when the line has stayed quiet for a programmed number of character times after the most recent character. When a transfer closes, a partly filled word is flushed to the buffer with zero in its unused upper bytes, and the number of characters the transfer held is latched for the host to read. Single-cycle command inputs arm and disarm idle detection, clear the idle flag, and clear the error flags.

Top module: `uart_rx_pack`

## Requirements
- R1: Within a word, the first character of a group of four sits in bits 7:0, the second in 15:8, the third in 23:16 and the fourth in 31:24; a word enters the buffer as soon as its fourth character arrives.
- R2: `rx_ready` is high exactly while the buffer holds at least one word; `rd_data` shows the oldest word, and a cycle with `rd_en` high removes it.
- R3: A pulse on `len_wr` opens a transfer of `len_in` characters (1 or more); when the last of them arrives the transfer closes and `snap_total` becomes `len_in`.
- R4: With idle detection armed, a transfer that has received at least one character closes once the line has been idle for `stale_chars` × 160 oversampling ticks after the last stop bit; `stale_irq` goes high and `snap_total` takes the number of characters received.
- R5: When a transfer closes with one to three characters not yet stored, they are pushed as one word whose unused upper bytes are zero.
- R6: The idle timer does not run before the first character of a transfer, so an open transfer with no characters never raises `stale_irq`.
- R7: `stale_dis_cmd` disarms idle detection, so no idle close happens however long the line is quiet; `stale_en_cmd` arms it again and the timeout then runs from the arming.
- R8: `stale_clr_cmd` clears `stale_irq`.
- R9: Characters that arrive while no transfer is open are discarded: they reach neither the buffer nor `snap_total`.
- R10: A word that has to enter a full buffer in a cycle without `rd_en` is dropped and `overrun` goes high; `err_clr_cmd` clears it.
- R11: A frame whose stop bit samples low raises `frame_err` and its character is discarded; the receiver waits for the line to return high; `err_clr_cmd` clears `frame_err`.
- R12: When a word must be stored in the very cycle that `rd_en` removes the oldest word from a full buffer, both happen and `overrun` stays low.
- R13: After reset, `rx_ready`, `overrun`, `frame_err` and `stale_irq` are low and `snap_total` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling strobe, sixteen per bit time |
| rxd | input | 1 | Serial line, idle high |
| len_wr | input | 1 | Opens a new transfer of `len_in` characters |
| len_in | input | LEN_W | Transfer length in characters |
| stale_chars | input | STO_W | Idle timeout in character times |
| stale_en_cmd | input | 1 | Arms idle detection |
| stale_dis_cmd | input | 1 | Disarms idle detection |
| stale_clr_cmd | input | 1 | Clears `stale_irq` |
| err_clr_cmd | input | 1 | Clears `overrun` and `frame_err` |
| rd_en | input | 1 | Removes the oldest word |
| rd_data | output | 32 | Oldest stored word |
| rx_ready | output | 1 | At least one word stored |
| overrun | output | 1 | A word was lost to a full buffer |
| frame_err | output | 1 | A stop bit sampled low |
| stale_irq | output | 1 | A transfer closed on idle timeout |
| snap_total | output | LEN_W | Characters held by the last closed transfer |

## Verification
The store of a completed word and a host read of the oldest word can land in the same cycle, and on a full buffer that cycle decides between an overrun and a clean exchange. The bench fills the buffer to its depth, then raises `rd_en` for exactly the cycle in which the final character of the transfer is stored, a cycle it counts from the start edge it drives itself. It then expects `overrun` low, the popped word to have been the oldest one, and the remaining four words, including the newly stored one, to come out in order.

// File: rtl/uart_rx_pack.sv
module uart_rx_pack #(
  parameter int OSR   = 16,
  parameter int DEPTH = 4,
  parameter int LEN_W = 12,
  parameter int STO_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rxd,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_in,
  input  logic [STO_W-1:0] stale_chars,
  input  logic             stale_en_cmd,
  input  logic             stale_dis_cmd,
  input  logic             stale_clr_cmd,
  input  logic             err_clr_cmd,
  input  logic             rd_en,
  output logic [31:0]      rd_data,
  output logic             rx_ready,
  output logic             overrun,
  output logic             frame_err,
  output logic             stale_irq,
  output logic [LEN_W-1:0] snap_total
);
  localparam int AW         = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BW         = $clog2(OSR);
  localparam int CHAR_TICKS = 10 * OSR;
  localparam int TW         = STO_W + $clog2(CHAR_TICKS) + 1;
  localparam logic [BW-1:0] TC_LAST = BW'(OSR - 1);
  localparam logic [BW-1:0] TC_MID  = BW'(OSR / 2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_WAITHI} st_t;

  logic s1, s2;
  st_t st;
  logic [BW-1:0] tc;
  logic [2:0] bc;
  logic [7:0] sh, bq;
  logic bv;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; tc <= '0; bc <= '0; sh <= '0; bq <= '0; bv <= 1'b0; frame_err <= 1'b0;
    end else begin
      bv <= 1'b0;
      if (err_clr_cmd) frame_err <= 1'b0;
      case (st)
        S_IDLE: if (!s2) begin st <= S_START; tc <= '0; end
        S_START: if (tick) begin
          if (tc == TC_MID) begin
            st <= s2 ? S_IDLE : S_DATA;
            tc <= '0;
            bc <= '0;
          end else tc <= tc + 1'b1;
        end
        S_DATA: if (tick) begin
          if (tc == TC_LAST) begin
            tc <= '0;
            sh <= {s2, sh[7:1]};
            bc <= bc + 1'b1;
            if (bc == 3'd7) st <= S_STOP;
          end else tc <= tc + 1'b1;
        end
        S_STOP: if (tick) begin
          if (tc == TC_LAST) begin
            tc <= '0;
            if (s2) begin
              bv <= 1'b1;
              bq <= sh;
              st <= S_IDLE;
            end else begin
              frame_err <= 1'b1;
              st <= S_WAITHI;
            end
          end else tc <= tc + 1'b1;
        end
        S_WAITHI: if (s2) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end

  logic active, sen;
  logic [LEN_W-1:0] len, cnt;
  logic [1:0] bi;
  logic [31:0] pack;
  logic [TW-1:0] tmr;

  wire [TW-1:0] thr       = TW'(stale_chars) * TW'(CHAR_TICKS);
  wire          last_char = active && bv && (cnt + 1'b1 == len);
  wire          tmr_run   = active && sen && (cnt != '0) && (st == S_IDLE) && !bv;
  wire          stale_hit = tmr_run && tick && (tmr == thr - 1'b1);
  wire [31:0]   merged    = pack | ({24'b0, bq} << {bi, 3'b000});

  logic push;
  logic [31:0] push_data;
  always_comb begin
    push = 1'b0;
    push_data = merged;
    if (active && bv) push = (bi == 2'd3) || last_char;
    else if (stale_hit && bi != 2'd0) begin
      push = 1'b1;
      push_data = pack;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0; len <= '0; cnt <= '0; bi <= '0; pack <= '0; snap_total <= '0;
    end else if (len_wr) begin
      active <= 1'b1; len <= len_in; cnt <= '0; bi <= '0; pack <= '0;
    end else if (active && bv) begin
      cnt <= cnt + 1'b1;
      if (push) begin
        pack <= '0;
        bi <= '0;
      end else begin
        pack <= merged;
        bi <= bi + 1'b1;
      end
      if (last_char) begin
        active <= 1'b0;
        snap_total <= cnt + 1'b1;
      end
    end else if (stale_hit) begin
      active <= 1'b0;
      snap_total <= cnt;
      pack <= '0;
      bi <= '0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sen <= 1'b0; stale_irq <= 1'b0; tmr <= '0;
    end else begin
      if (stale_en_cmd) sen <= 1'b1;
      if (stale_dis_cmd) sen <= 1'b0;
      if (stale_clr_cmd) stale_irq <= 1'b0;
      if (stale_hit) stale_irq <= 1'b1;
      if (!tmr_run) tmr <= '0;
      else if (tick) tmr <= tmr + 1'b1;
    end

  logic [31:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0] fcnt;
  wire full = (fcnt == (AW+1)'(DEPTH));
  wire pop  = rd_en && (fcnt != '0);
  wire wr   = push && (!full || pop);

  always_ff @(posedge clk) if (wr) mem[wp] <= push_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; fcnt <= '0; overrun <= 1'b0;
    end else begin
      if (wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({wr, pop})
        2'b10:   fcnt <= fcnt + 1'b1;
        2'b01:   fcnt <= fcnt - 1'b1;
        default: fcnt <= fcnt;
      endcase
      if (err_clr_cmd) overrun <= 1'b0;
      if (push && full && !pop) overrun <= 1'b1;
    end

  assign rd_data  = mem[rp];
  assign rx_ready = (fcnt != '0);

  AST_READY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(rd_en)); // R2
  AST_COUNT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (last_char && !len_wr) |=> (!active && snap_total == $past(len))); // R3
  AST_STALE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stale_irq) |-> $past(sen && cnt != '0)); // R6
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(push && full && !rd_en)); // R10
  AST_FRAME_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> $past(st == S_STOP && !s2)); // R11
endmodule

// File: tb/uart_rx_pack_tb.sv
module uart_rx_pack_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, rxd = 1'b1;
  logic len_wr = 0, stale_en_cmd = 0, stale_dis_cmd = 0, stale_clr_cmd = 0, err_clr_cmd = 0, rd_en = 0;
  logic [11:0] len_in = '0;
  logic [5:0] stale_chars = 6'd2;
  logic [31:0] rd_data;
  logic rx_ready, overrun, frame_err, stale_irq;
  logic [11:0] snap_total;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  uart_rx_pack u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .len_wr(len_wr), .len_in(len_in),
    .stale_chars(stale_chars), .stale_en_cmd(stale_en_cmd), .stale_dis_cmd(stale_dis_cmd),
    .stale_clr_cmd(stale_clr_cmd), .err_clr_cmd(err_clr_cmd), .rd_en(rd_en), .rd_data(rd_data),
    .rx_ready(rx_ready), .overrun(overrun), .frame_err(frame_err), .stale_irq(stale_irq),
    .snap_total(snap_total));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(logic [7:0] b, logic stop = 1'b1);
    @(negedge clk) rxd = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (16) @(negedge clk);
    end
    rxd = stop;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic open_xfer(int n);
    @(negedge clk) begin len_in = 12'(n); len_wr = 1'b1; end
    @(negedge clk) len_wr = 1'b0;
  endtask

  task automatic pulse_en();  @(negedge clk) stale_en_cmd = 1;  @(negedge clk) stale_en_cmd = 0;  endtask
  task automatic pulse_dis(); @(negedge clk) stale_dis_cmd = 1; @(negedge clk) stale_dis_cmd = 0; endtask
  task automatic pulse_sclr(); @(negedge clk) stale_clr_cmd = 1; @(negedge clk) stale_clr_cmd = 0; endtask
  task automatic pulse_eclr(); @(negedge clk) err_clr_cmd = 1; @(negedge clk) err_clr_cmd = 0; endtask

  task automatic read_word(string req, logic [31:0] exp);
    @(negedge clk);
    check(req, {31'b0, rx_ready}, 32'd1);
    check(req, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R13 rx_ready", {31'b0, rx_ready}, 0);
    check("R13 overrun", {31'b0, overrun}, 0);
    check("R13 frame_err", {31'b0, frame_err}, 0);
    check("R13 stale_irq", {31'b0, stale_irq}, 0);
    check("R13 snap", {20'b0, snap_total}, 0);
  endtask

  task automatic t_pack();
    open_xfer(8);
    for (int k = 1; k <= 8; k++) send_byte(8'(k * 8'h11));
    check("R3 snap", {20'b0, snap_total}, 8);
    read_word("R1 word0", 32'h44332211);
    read_word("R1 word1", 32'h88776655);
    @(negedge clk) check("R2 empty", {31'b0, rx_ready}, 0);
  endtask

  task automatic t_stale();
    pulse_en();
    open_xfer(16);
    for (int k = 0; k < 5; k++) send_byte(8'hA0 + 8'(k));
    check("R1 early push", {31'b0, rx_ready}, 1);
    repeat (150) @(negedge clk);
    check("R4 not yet", {31'b0, stale_irq}, 0);
    repeat (300) @(negedge clk);
    check("R4 stale_irq", {31'b0, stale_irq}, 1);
    check("R4 snap", {20'b0, snap_total}, 5);
    read_word("R1 full word", 32'hA3A2A1A0);
    read_word("R5 partial", 32'h000000A4);
    pulse_sclr();
    @(negedge clk) check("R8 cleared", {31'b0, stale_irq}, 0);
  endtask

  task automatic t_nochar_and_dis();
    open_xfer(4);
    repeat (700) @(negedge clk);
    check("R6 no char", {31'b0, stale_irq}, 0);
    pulse_dis();
    send_byte(8'h5A);
    repeat (700) @(negedge clk);
    check("R7 disarmed", {31'b0, stale_irq}, 0);
    check("R7 held", {31'b0, rx_ready}, 0);
    pulse_en();
    repeat (400) @(negedge clk);
    check("R7 rearmed", {31'b0, stale_irq}, 1);
    check("R7 snap", {20'b0, snap_total}, 1);
    read_word("R7 word", 32'h0000005A);
    pulse_sclr();
  endtask

  task automatic t_closed();
    send_byte(8'h77);
    repeat (4) @(negedge clk);
    check("R9 dropped", {31'b0, rx_ready}, 0);
    check("R9 snap kept", {20'b0, snap_total}, 1);
    open_xfer(4);
    for (int k = 1; k <= 4; k++) send_byte(8'(k));
    check("R9 snap", {20'b0, snap_total}, 4);
    read_word("R9 word", 32'h04030201);
    pulse_dis();
  endtask

  task automatic t_overrun();
    open_xfer(20);
    for (int k = 0; k < 20; k++) send_byte(8'h20 + 8'(k));
    check("R10 overrun", {31'b0, overrun}, 1);
    check("R10 snap", {20'b0, snap_total}, 20);
    for (int w = 0; w < 4; w++)
      read_word("R10 kept", {8'h23 + 8'(4*w), 8'h22 + 8'(4*w), 8'h21 + 8'(4*w), 8'h20 + 8'(4*w)});
    @(negedge clk) check("R10 dropped", {31'b0, rx_ready}, 0);
    pulse_eclr();
    @(negedge clk) check("R10 cleared", {31'b0, overrun}, 0);
  endtask

  task automatic t_frame();
    open_xfer(4);
    send_byte(8'hE7, 1'b0);
    repeat (20) @(negedge clk);
    check("R11 frame_err", {31'b0, frame_err}, 1);
    check("R11 discarded", {31'b0, rx_ready}, 0);
    for (int k = 0; k < 4; k++) send_byte(8'hC0 + 8'(k));
    check("R11 snap", {20'b0, snap_total}, 4);
    read_word("R11 clean word", 32'hC3C2C1C0);
    pulse_eclr();
    @(negedge clk) check("R11 cleared", {31'b0, frame_err}, 0);
  endtask

  task automatic t_same_cycle();
    open_xfer(20);
    for (int k = 0; k < 19; k++) send_byte(8'h40 + 8'(k));
    fork
      send_byte(8'h53);
      begin
        repeat (156) @(negedge clk);
        check("R12 head", rd_data, 32'h43424140);
        rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
      end
    join
    check("R12 no overrun", {31'b0, overrun}, 0);
    for (int w = 1; w < 5; w++)
      read_word("R12 order", {8'h43 + 8'(4*w), 8'h42 + 8'(4*w), 8'h41 + 8'(4*w), 8'h40 + 8'(4*w)});
    @(negedge clk) check("R12 empty", {31'b0, rx_ready}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pack();
    t_stale();
    t_nochar_and_dis();
    t_closed();
    t_overrun();
    t_frame();
    t_same_cycle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule